// File: doc/BRIEF.md
# Frame Difference Motion Mask

This block sits on the camera pixel clock and marks, pixel by pixel, where the scene has changed since the last frame. Each incoming pixel is 16-bit RGB565, qualified by a pixel enable and accompanied by frame and line sync. The block widens each colour field to 8 bits and reduces the pixel to an 8-bit luma value. It then sends that luma out, with its own delayed sync, so an external frame store can write it at the same pixel position.

The frame store returns the luma it held for the same position in the previous frame. That value arrives one clock after the current luma was presented. The block lines the two values up and takes their unsigned absolute difference. It then compares the difference with an 8-bit threshold and emits a one-bit motion flag per pixel, together with sync delayed by the same number of cycles. The frame memory is not part of the block. At power-up the threshold is normally set to 40.

Pipeline registers advance only on enabled pixels, so gaps in the pixel stream (enable low inside a line) leave pixels still in flight undisturbed.

Top module: `motion_mask`

## Requirements
- R1: The input pixel carries red in bits 15:11, green in bits 10:5 and blue in bits 4:0. Each field is widened to 8 bits by appending its own top bits: red 5 bits plus its 3 MSBs, green 6 bits plus its 2 MSBs, blue 5 bits plus its 3 MSBs. For example, 0xFFFF gives luma 255, 0xF800 gives 76, 0x07E0 gives 149, 0x001F gives 28 and 0x8410 gives 130.
- R2: The current luma is floor((77·R + 150·G + 29·B) / 256) of the widened channels. It appears on `lumaOut` with `lumaEn` high exactly 3 clocks after the pixel was taken with `enIn` high.
- R3: `lumaVsync`, `lumaHref` and `lumaEn` equal `vsyncIn`, `hrefIn` and `enIn` delayed by exactly 3 clocks.
- R4: The previous-frame luma for a pixel is sampled from `prevLuma` on the clock edge that ends the cycle after the one in which that pixel's luma was shown with `lumaEn` high.
- R5: `maskBit` is 1 when |current luma − previous luma| is strictly greater than `thresh`, and 0 otherwise. A difference equal to the threshold gives 0.
- R6: `maskVsync`, `maskHref` and `maskEn` equal `vsyncIn`, `hrefIn` and `enIn` delayed by exactly 5 clocks.
- R7: With `thresh` = 255, no pixel is flagged. With `thresh` = 0 and a frame identical to the one before it, no pixel is flagged.
- R8: While `rstN` is low, every output is 0.
- R9: Cycles with the pixel enable low do not advance the datapath. `lumaOut` keeps its last value while `lumaEn` is low, and pixels in flight are unaffected by gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pixIn | input | 16 | RGB565 pixel |
| vsyncIn | input | 1 | Frame sync |
| hrefIn | input | 1 | Line valid |
| enIn | input | 1 | Pixel qualifier |
| thresh | input | 8 | Motion threshold |
| prevLuma | input | 8 | Previous-frame luma returned by the frame store |
| lumaOut | output | 8 | Current luma to the frame store |
| lumaVsync | output | 1 | Frame sync aligned with lumaOut |
| lumaHref | output | 1 | Line valid aligned with lumaOut |
| lumaEn | output | 1 | Write strobe aligned with lumaOut |
| maskBit | output | 1 | Motion flag, 1 = motion |
| maskVsync | output | 1 | Frame sync aligned with maskBit |
| maskHref | output | 1 | Line valid aligned with maskBit |
| maskEn | output | 1 | Qualifier aligned with maskBit |

## Verification
The bench builds the block with its default weights: 77, 150 and 29 with an 8-bit shift. It drives 8×4-pixel frames. These small frames let a one-frame delay model of the store wrap many times, so every pixel's previous luma comes from real earlier output rather than from the store's cleared state. Solid colour frames set the luma difference to exactly 76 against thresholds of 76 and 75, which hits the strict-comparison edge. Random frames with enable gaps inside lines test stalls between the luma export and the return of the previous value.

// File: rtl/mmask_pkg.sv
package mmask_pkg;

  localparam int CH_W           = 8;
  localparam int NCH            = 3;
  localparam int LUMA_LAT       = 3;
  localparam int PREV_GAP       = 1;
  localparam int MASK_LAT       = LUMA_LAT + PREV_GAP + 1;
  localparam int DEFAULT_THRESH = 40;

  typedef struct packed {
    logic vsync;
    logic href;
    logic en;
  } syncT;

  // Per-stage load strobes from the control to the datapath
  typedef struct packed {
    logic ldExp;
    logic ldProd;
    logic ldSum;
    logic ldHold;
    logic ldMask;
  } stageStrobeT;

endpackage

// File: rtl/mmask_ctrl.sv
module mmask_ctrl
  import mmask_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  syncT        syncIn,
  output stageStrobeT stb,
  output syncT        lumaSync,
  output syncT        maskSync
);

  syncT [MASK_LAT-1:0] dly;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dly <= '0;
    else       dly <= {dly[MASK_LAT-2:0], syncIn};
  end

  // Each stage loads when the pixel it is about to take is enabled
  always_comb begin
    stb.ldExp  = syncIn.en;
    stb.ldProd = dly[0].en;
    stb.ldSum  = dly[1].en;
    stb.ldHold = dly[LUMA_LAT-1].en;
    stb.ldMask = dly[LUMA_LAT].en;
  end

  assign lumaSync = dly[LUMA_LAT-1];
  assign maskSync = dly[MASK_LAT-1];

endmodule

// File: rtl/mmask_datapath.sv
module mmask_datapath
  import mmask_pkg::*;
#(
  parameter int KR     = 77,
  parameter int KG     = 150,
  parameter int KB     = 29,
  parameter int KSHIFT = 8
)(
  input  logic            clk,
  input  logic            rstN,
  input  stageStrobeT     stb,
  input  logic [15:0]     pixIn,
  input  logic [CH_W-1:0] prevLuma,
  input  logic [CH_W-1:0] thresh,
  output logic [CH_W-1:0] lumaCur,
  output logic            maskBit
);

  localparam int PROD_W = CH_W + 8;
  localparam int SUM_W  = PROD_W + 2;

  logic [NCH-1:0][CH_W-1:0]   expRgb;
  logic [NCH-1:0][CH_W-1:0]   rgbQ;
  logic [NCH-1:0][PROD_W-1:0] prodBus;
  logic [SUM_W-1:0]           sumWide;
  logic [CH_W-1:0]            lumaQ;
  logic [CH_W-1:0]            holdQ;
  logic [CH_W-1:0]            absDiff;
  logic                       maskQ;

  // Stage 1: widen each field by repeating its top bits
  always_comb begin
    expRgb[0] = {pixIn[15:11], pixIn[15:13]};
    expRgb[1] = {pixIn[10:5],  pixIn[10:9]};
    expRgb[2] = {pixIn[4:0],   pixIn[4:2]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rgbQ <= '0;
    else if (stb.ldExp) rgbQ <= expRgb;
  end

  // Stage 2: one weighted product per channel
  generate
    for (genvar c = 0; c < NCH; c++) begin : g_prod
      localparam int K = (c == 0) ? KR : ((c == 1) ? KG : KB);
      localparam logic [PROD_W-1:0] KV = PROD_W'(K);
      logic [PROD_W-1:0] prodQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)           prodQ <= '0;
        else if (stb.ldProd) prodQ <= KV * PROD_W'(rgbQ[c]);
      end
      assign prodBus[c] = prodQ;
    end
  endgenerate

  // Stage 3: sum and scale
  assign sumWide = SUM_W'(prodBus[0]) + SUM_W'(prodBus[1]) + SUM_W'(prodBus[2]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          lumaQ <= '0;
    else if (stb.ldSum) lumaQ <= CH_W'(sumWide >> KSHIFT);
  end

  // Hold the exported luma one cycle until the stored value returns
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           holdQ <= '0;
    else if (stb.ldHold) holdQ <= lumaQ;
  end

  assign absDiff = (holdQ >= prevLuma) ? (holdQ - prevLuma) : (prevLuma - holdQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           maskQ <= 1'b0;
    else if (stb.ldMask) maskQ <= (absDiff > thresh);
  end

  assign lumaCur = lumaQ;
  assign maskBit = maskQ;

endmodule

// File: rtl/motion_mask.sv
module motion_mask
  import mmask_pkg::*;
#(
  parameter int KR     = 77,
  parameter int KG     = 150,
  parameter int KB     = 29,
  parameter int KSHIFT = 8
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] pixIn,
  input  logic        vsyncIn,
  input  logic        hrefIn,
  input  logic        enIn,
  input  logic [7:0]  thresh,
  input  logic [7:0]  prevLuma,
  output logic [7:0]  lumaOut,
  output logic        lumaVsync,
  output logic        lumaHref,
  output logic        lumaEn,
  output logic        maskBit,
  output logic        maskVsync,
  output logic        maskHref,
  output logic        maskEn
);

  syncT        syncIn;
  syncT        lumaSync;
  syncT        maskSync;
  stageStrobeT stb;

  assign syncIn = '{vsync: vsyncIn, href: hrefIn, en: enIn};

  mmask_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .syncIn   (syncIn),
    .stb      (stb),
    .lumaSync (lumaSync),
    .maskSync (maskSync)
  );

  mmask_datapath #(
    .KR     (KR),
    .KG     (KG),
    .KB     (KB),
    .KSHIFT (KSHIFT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .pixIn    (pixIn),
    .prevLuma (prevLuma),
    .thresh   (thresh),
    .lumaCur  (lumaOut),
    .maskBit  (maskBit)
  );

  assign lumaVsync = lumaSync.vsync;
  assign lumaHref  = lumaSync.href;
  assign lumaEn    = lumaSync.en;
  assign maskVsync = maskSync.vsync;
  assign maskHref  = maskSync.href;
  assign maskEn    = maskSync.en;

endmodule

// File: rtl/mmask_checker.sv
module mmask_checker (
  input logic       clk,
  input logic       rstN,
  input logic       vsyncIn,
  input logic       hrefIn,
  input logic       enIn,
  input logic [7:0] thresh,
  input logic [7:0] prevLuma,
  input logic [7:0] lumaOut,
  input logic       lumaVsync,
  input logic       lumaHref,
  input logic       lumaEn,
  input logic       maskBit,
  input logic       maskVsync,
  input logic       maskHref,
  input logic       maskEn
);

  logic [2:0] upCnt;
  logic       warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             upCnt <= '0;
    else if (upCnt != 3'd7) upCnt <= upCnt + 3'd1;
  end
  assign warm = (upCnt >= 3'd5);

  function automatic logic [7:0] absd(input logic [7:0] a, input logic [7:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  p_luma_sync_r3: assert property (@(posedge clk) disable iff (!rstN)
    warm |-> (lumaEn == $past(enIn, 3)) && (lumaHref == $past(hrefIn, 3))
             && (lumaVsync == $past(vsyncIn, 3)));

  p_mask_sync_r6: assert property (@(posedge clk) disable iff (!rstN)
    warm |-> (maskEn == $past(enIn, 5)) && (maskHref == $past(hrefIn, 5))
             && (maskVsync == $past(vsyncIn, 5)));

  // R4 and R5: flag built from the luma shown two cycles back and the value returned one cycle back
  p_mask_rule_r5: assert property (@(posedge clk) disable iff (!rstN)
    (warm && maskEn) |-> maskBit == (absd($past(lumaOut, 2), $past(prevLuma)) > $past(thresh)));

  p_thr_max_r7: assert property (@(posedge clk) disable iff (!rstN)
    (warm && maskEn && $past(thresh) == 8'hFF) |-> !maskBit);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (warm && !lumaEn) |-> $stable(lumaOut));

endmodule

bind motion_mask mmask_checker u_chk (.*);

// File: tb/sim_motion_mask.sv
module sim_motion_mask;
  import mmask_pkg::*;

  localparam int W    = 8;
  localparam int H    = 4;
  localparam int NPIX = W * H;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] pixIn = '0;
  logic        vsyncIn = 1'b0, hrefIn = 1'b0, enIn = 1'b0;
  logic [7:0]  thresh = 8'(DEFAULT_THRESH);
  logic [7:0]  prevLuma = '0;
  logic [7:0]  lumaOut;
  logic        lumaVsync, lumaHref, lumaEn;
  logic        maskBit, maskVsync, maskHref, maskEn;

  always #10 clk = ~clk;

  motion_mask u0 (.*);

  int nChk = 0, nBad = 0;
  int lumaQ[$], maskQ[$];
  int refFrame[NPIX];
  int refIdx = 0;
  int storeMem[NPIX];
  int storeIdx = 0;
  int nextPrev = 0;
  int lumaCnt = 0, lastLuma = 0, maskOnes = 0;
  bit seenLuma = 0, running = 0;
  bit enH[5], vsH[5], hrH[5];
  logic [15:0] fr[NPIX];
  int lit[5] = '{255, 76, 149, 28, 130};

  task automatic check(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int refLuma(logic [15:0] p);
    int r, g, b;
    r = int'({p[15:11], p[15:13]});
    g = int'({p[10:5], p[10:9]});
    b = int'({p[4:0], p[4:2]});
    return (77 * r + 150 * g + 29 * b) / 256;
  endfunction

  // input history sampled at the active edge
  always @(posedge clk) begin
    for (int k = 4; k > 0; k--) begin
      enH[k] <= enH[k-1]; vsH[k] <= vsH[k-1]; hrH[k] <= hrH[k-1];
    end
    enH[0] <= enIn; vsH[0] <= vsyncIn; hrH[0] <= hrefIn;
  end

  // one-frame delay store: returns the old value one cycle after the write (R4)
  always @(negedge clk) begin
    prevLuma = 8'(nextPrev);
    if (rstN && lumaEn) begin
      nextPrev = storeMem[storeIdx];
      storeMem[storeIdx] = int'(lumaOut);
      storeIdx = (storeIdx + 1) % NPIX;
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (running) begin
      check(lumaEn == enH[2] && lumaHref == hrH[2] && lumaVsync == vsH[2],
            "R3 luma sync", {lumaVsync, lumaHref, lumaEn}, {vsH[2], hrH[2], enH[2]});
      check(maskEn == enH[4] && maskHref == hrH[4] && maskVsync == vsH[4],
            "R6 mask sync", {maskVsync, maskHref, maskEn}, {vsH[4], hrH[4], enH[4]});
      if (lumaEn) begin
        if (lumaQ.size() == 0) check(0, "R2 unexpected luma", int'(lumaOut), -1);
        else begin
          int e;
          e = lumaQ.pop_front();
          check(int'(lumaOut) == e, "R2 luma value", int'(lumaOut), e);
        end
        if (lumaCnt < 5) check(int'(lumaOut) == lit[lumaCnt], "R1 widening", int'(lumaOut), lit[lumaCnt]);
        lumaCnt++;
        lastLuma = int'(lumaOut);
        seenLuma = 1;
      end else if (seenLuma) begin
        check(int'(lumaOut) == lastLuma, "R9 luma hold", int'(lumaOut), lastLuma);
      end
      if (maskEn) begin
        if (maskQ.size() == 0) check(0, "R5 unexpected mask", int'(maskBit), -1);
        else begin
          int e;
          e = maskQ.pop_front();
          check(int'(maskBit) == e, "R5 R4 mask value", int'(maskBit), e);
        end
        maskOnes += int'(maskBit);
      end
    end
  end

  task automatic drive(logic [15:0] p, bit en, bit vs, bit hr);
    @(negedge clk);
    pixIn = p; enIn = en; vsyncIn = vs; hrefIn = hr;
    if (en) begin
      int y, d;
      y = refLuma(p);
      d = (y > refFrame[refIdx]) ? y - refFrame[refIdx] : refFrame[refIdx] - y;
      lumaQ.push_back(y);
      maskQ.push_back((d > int'(thresh)) ? 1 : 0);
      refFrame[refIdx] = y;
      refIdx = (refIdx + 1) % NPIX;
    end
  endtask

  task automatic sendFrame(int thr, bit gaps);
    @(negedge clk);
    thresh = 8'(thr);
    maskOnes = 0;
    drive('0, 0, 1, 0);
    drive('0, 0, 1, 0);
    drive('0, 0, 0, 0);
    for (int row = 0; row < H; row++) begin
      for (int col = 0; col < W; col++) begin
        if (gaps && ($urandom() % 3 == 0)) drive(16'($urandom()), 0, 0, 1);
        drive(fr[row * W + col], 1, 0, 1);
      end
      drive('0, 0, 0, 0);
      drive('0, 0, 0, 0);
    end
    repeat (8) drive('0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < NPIX; i++) begin refFrame[i] = 0; storeMem[i] = 0; end
    repeat (3) @(negedge clk);
    check(lumaOut == 0 && !lumaEn && !lumaHref && !lumaVsync, "R8 reset luma side",
          {lumaOut, lumaVsync, lumaHref, lumaEn}, 0);
    check(!maskBit && !maskEn && !maskHref && !maskVsync, "R8 reset mask side",
          {maskBit, maskVsync, maskHref, maskEn}, 0);
    rstN = 1'b1;
    running = 1;

    // R1 calibration colours
    for (int i = 0; i < NPIX; i++) fr[i] = '0;
    fr[0] = 16'hFFFF; fr[1] = 16'hF800; fr[2] = 16'h07E0; fr[3] = 16'h001F; fr[4] = 16'h8410;
    sendFrame(DEFAULT_THRESH, 0);

    for (int i = 0; i < NPIX; i++) fr[i] = '0;
    sendFrame(DEFAULT_THRESH, 0);

    // R5 edge: difference 76 against threshold 76 and 75
    for (int i = 0; i < NPIX; i++) fr[i] = 16'hF800;
    sendFrame(76, 1);
    check(maskOnes == 0, "R5 diff equal to threshold", maskOnes, 0);
    for (int i = 0; i < NPIX; i++) fr[i] = '0;
    sendFrame(75, 1);
    check(maskOnes == NPIX, "R5 diff one above threshold", maskOnes, NPIX);

    // random frames with gaps
    for (int f = 0; f < 8; f++) begin
      for (int i = 0; i < NPIX; i++) fr[i] = 16'($urandom());
      sendFrame(int'($urandom() % 256), 1);
    end

    // R7: maximum threshold, then identical frame at zero threshold
    for (int i = 0; i < NPIX; i++) fr[i] = 16'($urandom());
    sendFrame(255, 1);
    check(maskOnes == 0, "R7 threshold 255", maskOnes, 0);
    sendFrame(0, 1);
    check(maskOnes == 0, "R7 repeated frame threshold 0", maskOnes, 0);

    check(lumaQ.size() == 0 && maskQ.size() == 0, "R2 R5 all pixels emerged",
          lumaQ.size() + maskQ.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule